// File: doc/BRIEF.md
# Interrupt Pending and Priority Controller

This block gathers interrupt requests from eleven sources around a small 8-bit processor core. It holds a pending latch for each source and gates that latch with per-source enables and a global enable. It then chooses one winner across three priority levels and offers that winner to the core as a request with a vector index. When the core signals that it has entered a vector, the block marks that level as in service and clears the source's pending state, using the rule for that source's kind. A return strobe from the core pops the in-service level.

Sources fall into three kinds. **Latched** sources keep an internal latch that is set on a rising edge of their input. These are the two timers, the temperature converter, the serial (I2C/SPI) unit and the real-time clock. **Shared** sources follow a level driven by peripheral flags, and software must clear that level. These are the UART, Timer 2, the energy engine and the supply monitor. **External** sources come from two active-low pins, and each pin can be set to falling-edge or low-level mode. While the core sleeps, pin edges are ignored and a wake-up event sets a separate pending latch.

The handshake uses a three-state machine. `S_IDLE` means no offer is made. `S_OFFER` means `irq_req` is high with a registered vector. `S_ENTER` is a one-cycle settle after entry. The transitions are:
- `S_IDLE` goes to `S_OFFER` when an enabled pending request outranks every level in service.
- `S_OFFER` stays in `S_OFFER` and reloads the vector while such a request exists.
- `S_OFFER` goes back to `S_IDLE` when no request qualifies any more.
- `S_OFFER` goes to `S_ENTER` on `irq_ack`.
- `S_ENTER` always goes to `S_IDLE`.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, `irq_vec` is 0, and nothing is pending or in service.
- R2: An input change sampled at clock edge k makes `irq_req` rise at edge k+1. `irq_vec` gives the source index:
  - 0: external pin 0
  - 1: Timer 0
  - 2: external pin 1
  - 3: Timer 1
  - 4: UART
  - 5: Timer 2
  - 6: temperature
  - 7: serial
  - 8: real-time clock
  - 9: energy
  - 10: supply monitor
- R3: A latched source is set by a rising edge of its `periph_in` bit. It stays pending after that bit falls, and it is cleared only when its vector is entered. The `periph_in` bits map as follows:
  - bit 0: index 1
  - bit 1: index 3
  - bits 2 to 8: indices 4 to 10
- R4: A latched pending source whose `src_en` bit is 0 stays pending. It is offered once it is enabled.
- R5: A shared source (indices 4, 5, 9, 10) follows its input level. Vector entry does not clear it.
- R6: The supply monitor (index 10) is alone on the top level. It beats all other sources, and `glob_en` does not gate it.
- R7: `prio_hi[i]=1` places source i on the middle level, and 0 places it on the low level. Within one level, the lower index wins.
- R8: When `glob_en` is 0, every source except index 10 is masked.
- R9: A request is offered only when its level is above every level in service. `irq_ret` removes the highest level in service.
- R10: In falling-edge mode (`ext_fall_mode` bit = 1), an external source is set by a falling edge of its pin and cleared on entry.
- R11: In low-level mode, an external source stays requested while its pin is low. It is offered again after each return, until the pin goes high.
- R12: While `sleep_mode` is 1, pin edges and levels set nothing. A `wake_evt` pulse sets a pending request for that external source, and vector entry clears that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_mode | input | 1 | Core is in deepest sleep |
| wake_evt | input | 2 | Wake-up event per external source |
| ext_pin_n | input | 2 | External interrupt pins, active low |
| ext_fall_mode | input | 2 | 1 selects falling-edge mode, 0 selects low-level mode |
| periph_in | input | 9 | Peripheral request inputs (mapping in R3) |
| src_en | input | 11 | Per-source enable, by vector index |
| glob_en | input | 1 | Global enable, does not gate index 10 |
| prio_hi | input | 10 | Middle-level select for indices 0 to 9 |
| irq_ack | input | 1 | Core enters the offered vector |
| irq_ret | input | 1 | Core returns from an interrupt |
| irq_req | output | 1 | Request offered to the core |
| irq_vec | output | 4 | Offered vector index, 0 when no request |

## Verification
Every input path passes through one register into the pending latch and then through the offer register. A stimulus applied before edge k therefore appears on `irq_req` after edge k+1. After `irq_ack`, the request falls at the next edge, and the next winner can appear two edges later. After `irq_ret`, a request that was blocked appears one edge later. The bench drives inputs on falling clock edges and samples them on falling edges that it counts from these figures. Where a result must not appear, the bench waits beyond these latencies before it samples.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NSRC  = 11;
    localparam int NPER  = NSRC - 2;
    localparam int NPRI  = NSRC - 1;
    localparam int VW    = $clog2(NSRC);
    localparam int NLVL  = 3;
    localparam int LW    = $clog2(NLVL);
    localparam int IDX_EXT0 = 0;
    localparam int IDX_EXT1 = 2;
    localparam int IDX_PSM  = NSRC - 1;

    typedef enum logic [1:0] {K_EXT, K_LATCH, K_SHARED} kind_e;
    typedef enum logic [1:0] {S_IDLE, S_OFFER, S_ENTER} st_e;

    function automatic kind_e src_kind(int i);
        if (i == IDX_EXT0 || i == IDX_EXT1) return K_EXT;
        if (i == 4 || i == 5 || i == 9 || i == IDX_PSM) return K_SHARED;
        return K_LATCH;
    endfunction

    function automatic int per_bit(int i);
        return (i == 1) ? 0 : i - 2;
    endfunction
endpackage

// File: rtl/irqc_ext_src.sv
module irqc_ext_src (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic fall_mode,
    input  logic sleep,
    input  logic wake,
    input  logic clr,
    output logic pend
);
    logic pin_q, eflag_q, lvl_q, wake_q, fall;

    assign fall = pin_q & ~pin_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q   <= 1'b1;
            eflag_q <= 1'b0;
            lvl_q   <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            pin_q   <= pin_n;
            eflag_q <= fall_mode & ((fall & ~sleep) | (eflag_q & ~clr));
            lvl_q   <= ~fall_mode & ~sleep & ~pin_n;
            wake_q  <= (wake & sleep) | (wake_q & ~clr);
        end
    end

    assign pend = eflag_q | lvl_q | wake_q;

    a_r12_sleep_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !eflag_q) |=> !eflag_q);
    a_r10_edge_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && fall_mode && !fall) |=> !eflag_q);
    a_r11_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_mode && !pin_n && !sleep) |=> pend);
endmodule

// File: rtl/irqc_per_src.sv
module irqc_per_src #(
    parameter bit SHARED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    input  logic clr,
    output logic pend
);
    logic prev_q, pend_q, rise;

    assign rise = lvl_in & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= lvl_in;
            pend_q <= SHARED ? lvl_in : (rise | (pend_q & ~clr));
        end
    end

    assign pend = pend_q;

    a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> pend);
    a_r3_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr && (!SHARED || lvl_in)) |=> pend);
    a_r5_entry_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (SHARED && clr && lvl_in) |=> pend);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] en,
    input  logic            glob_en,
    input  logic [NPRI-1:0] prio_hi,
    output logic            win_valid,
    output logic [VW-1:0]   win_idx,
    output logic [LW-1:0]   win_lvl
);
    logic [NSRC-1:0] elig;
    logic [LW-1:0]   lvl [NSRC];

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            elig[i] = pend[i] & en[i] & ((i == IDX_PSM) ? 1'b1 : glob_en);
            lvl[i]  = (i == IDX_PSM) ? LW'(2) : (prio_hi[i % NPRI] ? LW'(1) : LW'(0));
        end
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i] && (!win_valid || lvl[i] >= win_lvl)) begin
                win_valid = 1'b1;
                win_idx   = VW'(i);
                win_lvl   = lvl[i];
            end
        end
    end
endmodule

// File: rtl/irqc_svc_stack.sv
module irqc_svc_stack
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [LW-1:0]   push_lvl,
    input  logic            pop,
    output logic [NLVL-1:0] svc
);
    logic [NLVL-1:0] svc_q, popped;

    always_comb begin
        popped = svc_q;
        if (pop) begin
            for (int i = 0; i < NLVL; i++) begin
                if (svc_q[i] && ((svc_q >> (i + 1)) == '0)) popped[i] = 1'b0;
            end
        end
        if (push) popped[push_lvl] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) svc_q <= '0;
        else        svc_q <= popped;
    end

    assign svc = svc_q;

    a_r9_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && svc_q != '0) |=> ($countones(svc_q) == $countones($past(svc_q)) - 1));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_mode,
    input  logic [1:0]      wake_evt,
    input  logic [1:0]      ext_pin_n,
    input  logic [1:0]      ext_fall_mode,
    input  logic [NPER-1:0] periph_in,
    input  logic [NSRC-1:0] src_en,
    input  logic            glob_en,
    input  logic [NPRI-1:0] prio_hi,
    input  logic            irq_ack,
    input  logic            irq_ret,
    output logic            irq_req,
    output logic [VW-1:0]   irq_vec
);
    st_e             st_q, st_d;
    logic [VW-1:0]   vec_q, vec_d;
    logic [LW-1:0]   lvl_q, lvl_d;
    logic [NSRC-1:0] pend, clr;
    logic [NLVL-1:0] svc;
    logic            win_valid, outrank, entry;
    logic [VW-1:0]   win_idx;
    logic [LW-1:0]   win_lvl;

    assign entry = (st_q == S_OFFER) && irq_ack;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign clr[i] = entry && (vec_q == VW'(i));
        if (src_kind(i) == K_EXT) begin : g_ext
            irqc_ext_src u_ext (
                .clk(clk), .rst_n(rst_n),
                .pin_n(ext_pin_n[i / 2]), .fall_mode(ext_fall_mode[i / 2]),
                .sleep(sleep_mode), .wake(wake_evt[i / 2]),
                .clr(clr[i]), .pend(pend[i]));
        end else begin : g_per
            irqc_per_src #(.SHARED(src_kind(i) == K_SHARED)) u_per (
                .clk(clk), .rst_n(rst_n),
                .lvl_in(periph_in[per_bit(i)]),
                .clr(clr[i]), .pend(pend[i]));
        end
    end

    irqc_arbiter u_arb (
        .pend(pend), .en(src_en), .glob_en(glob_en), .prio_hi(prio_hi),
        .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl));

    irqc_svc_stack u_svc (
        .clk(clk), .rst_n(rst_n), .push(entry), .push_lvl(lvl_q),
        .pop(irq_ret), .svc(svc));

    assign outrank = win_valid && ((svc >> win_lvl) == '0);

    always_comb begin
        st_d  = st_q;
        vec_d = vec_q;
        lvl_d = lvl_q;
        unique case (st_q)
            S_IDLE: if (outrank) begin
                st_d = S_OFFER; vec_d = win_idx; lvl_d = win_lvl;
            end
            S_OFFER: begin
                if (irq_ack)      st_d = S_ENTER;
                else if (outrank) begin vec_d = win_idx; lvl_d = win_lvl; end
                else              st_d = S_IDLE;
            end
            S_ENTER: st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            vec_q <= '0;
            lvl_q <= '0;
        end else begin
            st_q  <= st_d;
            vec_q <= vec_d;
            lvl_q <= lvl_d;
        end
    end

    always_comb begin
        irq_req = 1'b0;
        irq_vec = '0;
        unique case (st_q)
            S_OFFER: begin irq_req = 1'b1; irq_vec = vec_q; end
            default: ;
        endcase
    end

    a_r9_outranks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((svc >> lvl_q) == '0));
    a_r2_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req);
    a_r6_psm_top: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && lvl_q == LW'(2)) |-> (irq_vec == VW'(IDX_PSM)));
    a_r1_vec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_vec == '0));
endmodule

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sleep_mode;
    logic [1:0]  wake_evt, ext_pin_n, ext_fall_mode;
    logic [8:0]  periph_in;
    logic [10:0] src_en;
    logic        glob_en;
    logic [9:0]  prio_hi;
    logic        irq_ack, irq_ret;
    logic        irq_req;
    logic [3:0]  irq_vec;
    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_mode(sleep_mode), .wake_evt(wake_evt),
        .ext_pin_n(ext_pin_n), .ext_fall_mode(ext_fall_mode), .periph_in(periph_in),
        .src_en(src_en), .glob_en(glob_en), .prio_hi(prio_hi),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec));

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string rq, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic chk_irq(string rq, int r, int v);
        chk({rq, " req"}, int'(irq_req), r);
        if (r == 1) chk({rq, " vec"}, int'(irq_vec), v);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sleep_mode = 0; wake_evt = 0; ext_pin_n = 2'b11; ext_fall_mode = 0;
        periph_in = 0; src_en = '1; glob_en = 1; prio_hi = 0; irq_ack = 0; irq_ret = 0;
        wt(3);
        rst_n = 1'b1;
        wt(1);
    endtask

    task automatic pulse_ack();
        irq_ack = 1; wt(1); irq_ack = 0;
    endtask

    task automatic pulse_ret();
        irq_ret = 1; wt(1); irq_ret = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset", int'(irq_req), 0);
        chk("R1 reset vec", int'(irq_vec), 0);
        wt(4);
        chk_irq("R1 idle", 0, 0);
    endtask

    task automatic t_rtc_latched();
        do_reset();
        periph_in[6] = 1; wt(1); periph_in[6] = 0;
        chk_irq("R2 one edge", 0, 0);
        wt(1);
        chk_irq("R2 two edges", 1, 8);
        wt(2);
        chk_irq("R3 flag cleared keeps pending", 1, 8);
        pulse_ack();
        chk_irq("R2 ack drops", 0, 0);
        pulse_ret();
        wt(3);
        chk_irq("R3 cleared on entry", 0, 0);
    endtask

    task automatic t_disabled_hold();
        do_reset();
        src_en[7] = 0;
        periph_in[5] = 1; wt(1); periph_in[5] = 0;
        wt(4);
        chk_irq("R4 disabled", 0, 0);
        src_en[7] = 1;
        wt(2);
        chk_irq("R4 enabled later", 1, 7);
    endtask

    task automatic t_priority();
        do_reset();
        periph_in[0] = 1; periph_in[1] = 1; wt(1); periph_in = 0; wt(1);
        chk_irq("R7 tie lower index", 1, 1);
        pulse_ack(); pulse_ret(); wt(2);
        chk_irq("R7 next in level", 1, 3);
        do_reset();
        prio_hi[3] = 1;
        periph_in[0] = 1; periph_in[1] = 1; wt(1); periph_in = 0; wt(1);
        chk_irq("R7 middle level wins", 1, 3);
    endtask

    task automatic t_psm();
        do_reset();
        glob_en = 0;
        periph_in[8] = 1; periph_in[7] = 1;
        wt(2);
        chk_irq("R6 ignores global enable", 1, 10);
        do_reset();
        prio_hi = '1;
        periph_in[8] = 1; periph_in[6] = 1; wt(1); periph_in[6] = 0; wt(1);
        chk_irq("R6 beats middle level", 1, 10);
    endtask

    task automatic t_global();
        do_reset();
        glob_en = 0;
        periph_in[0] = 1; wt(1); periph_in[0] = 0;
        wt(3);
        chk_irq("R8 masked", 0, 0);
        glob_en = 1;
        wt(2);
        chk_irq("R8 unmasked", 1, 1);
    endtask

    task automatic t_nesting();
        do_reset();
        periph_in[7] = 1;
        wt(2);
        chk_irq("R5 energy offered", 1, 9);
        pulse_ack();
        wt(3);
        chk_irq("R9 same level blocked", 0, 0);
        prio_hi[8] = 1;
        periph_in[6] = 1; wt(1); periph_in[6] = 0; wt(1);
        chk_irq("R9 higher preempts", 1, 8);
        pulse_ack();
        pulse_ret();
        wt(3);
        chk_irq("R9 low level still in service", 0, 0);
        pulse_ret();
        wt(2);
        chk_irq("R5 not cleared by entry", 1, 9);
        periph_in[7] = 0;
        wt(2);
        chk_irq("R5 follows level", 0, 0);
    endtask

    task automatic t_ext_edge();
        do_reset();
        ext_fall_mode[0] = 1;
        ext_pin_n[0] = 0;
        wt(2);
        chk_irq("R10 falling edge", 1, 0);
        pulse_ack(); pulse_ret();
        wt(3);
        chk_irq("R10 cleared with pin low", 0, 0);
    endtask

    task automatic t_ext_level();
        do_reset();
        ext_pin_n[1] = 0;
        wt(2);
        chk_irq("R11 low level", 1, 2);
        pulse_ack(); pulse_ret();
        wt(2);
        chk_irq("R11 re-entered", 1, 2);
        ext_pin_n[1] = 1;
        wt(2);
        chk_irq("R11 pin high", 0, 0);
    endtask

    task automatic t_sleep();
        do_reset();
        ext_fall_mode[0] = 1;
        sleep_mode = 1;
        ext_pin_n[0] = 0;
        wt(4);
        chk_irq("R12 edge ignored asleep", 0, 0);
        wake_evt[0] = 1; wt(1); wake_evt[0] = 0;
        wt(1);
        chk_irq("R12 wake pending", 1, 0);
        pulse_ack(); pulse_ret();
        sleep_mode = 0;
        wt(3);
        chk_irq("R12 wake cleared on entry", 0, 0);
    endtask

    initial begin
        t_reset();
        t_rtc_latched();
        t_disabled_hold();
        t_priority();
        t_psm();
        t_global();
        t_nesting();
        t_ext_edge();
        t_ext_level();
        t_sleep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule